// File: doc/BRIEF.md
# Stereo Automatic Gain Limiter and Recovery Engine

This block steers the gain codes of a two-channel input amplifier. Each channel carries a 7-bit gain code from 0x00 (mute) to 0x68 (maximum). Once per sample frame the block receives a signed sample for each channel. When either channel's magnitude reaches a selected threshold, the block lowers both gains together in steps. When recovery is enabled and the input has stayed quiet for a programmed wait, it raises them again in steps toward a reference code.

A gain step is applied in one of two ways. In the first, both channels change at once, and limiter steps are spaced by a minimum update period. In the second, each channel holds the new code until its own sample changes sign, or until a timeout runs out. A completion flag shows that no step is in progress and the input is below the threshold. While the limiter is enabled, or while a step is pending, direct gain writes from the host are dropped. All configuration arrives on input ports.

Top module: `agc_limiter`

## Requirements
- R1: After reset both gain outputs are 0x30 and the completion flag `done` is 1.
- R2: A host write (`host_wr_l`/`host_wr_r` with `host_gain`) takes effect on the next clock edge only while `lim_en` is 0 and no step is pending. Values above 0x68 are stored as 0x68. Writes made while `lim_en` is 1 leave the gains unchanged.
- R3: A frame is over threshold when the magnitude of either sample is at or above T[`thr_sel`], where `thr_sel` 0..3 gives T = 13045, 16423, 20675, 26029 (16-bit samples). A magnitude one below T does not trigger.
- R4: A limiter step sets both channels to max(min(gain_l, gain_r) − (`atten_sel`+1), 0).
- R5: With `lim_zc_en`=0, limiter steps are applied in the frame that triggers them and are spaced at least 2^`lim_tm_sel` frames apart.
- R6: With zero-cross gating, a pending step is applied to a channel in the first frame whose sample sign bit differs from that channel's previous frame's sign bit. Failing that, it is applied in the N-th frame after the step was issued. For the limiter, N = 129·2^`lim_tm_sel`; for recovery, N = 512·2^`rcv_tm_sel` + 1. Between frames the gains hold.
- R7: `done` is 0 after any frame that was over threshold with `lim_en`=1, and while a step is pending. Otherwise it is 1.
- R8: With `lim_en`=`rcv_en`=1, a recovery step is issued on the 512·2^`wait_sel`-th consecutive quiet frame. It sets both channels to min(min(gain_l, gain_r) + `rise_sel`+1, `ref_code`). The wait counter then restarts. No step is issued when the gain is already at or above `ref_code`.
- R9: A frame that is not over threshold but whose peak magnitude is at or above the band level B[`thr_sel`] = 10362, 13045, 16423, 20675 resets the wait counter. A magnitude of B−1 counts as quiet.
- R10: A recovery step issued with `rcv_zc_en`=1 and no sign change completes exactly 513·… frames later, as given in R6 (513 frames for `rcv_tm_sel`=0).
- R11: An over-threshold frame that arrives while a recovery step is pending abandons that step at once and issues a limiter step computed from the smaller of the two current gains.
- R12: After `lim_en` is cleared, no new step is issued, a pending step still completes, and `done` returns to 1 once it has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l | input | DW | Left sample, two's complement |
| smp_r | input | DW | Right sample, two's complement |
| lim_en | input | 1 | Limiter enable |
| rcv_en | input | 1 | Recovery enable, effective only with `lim_en` |
| thr_sel | input | 2 | Threshold select |
| atten_sel | input | 3 | Limiter step size minus one |
| lim_zc_en | input | 1 | Zero-cross gating for limiter steps |
| lim_tm_sel | input | 2 | Limiter update period or timeout select |
| rcv_zc_en | input | 1 | Zero-cross gating for recovery steps |
| rcv_tm_sel | input | 2 | Recovery zero-cross timeout select |
| wait_sel | input | 2 | Recovery wait select |
| rise_sel | input | 2 | Recovery step size minus one |
| ref_code | input | 7 | Recovery ceiling code |
| host_wr_l | input | 1 | Host write strobe, left |
| host_wr_r | input | 1 | Host write strobe, right |
| host_gain | input | 7 | Host write value |
| gain_l | output | 7 | Left gain code |
| gain_r | output | 7 | Right gain code |
| done | output | 1 | Completion flag |

## Verification
The limiter is driven with magnitudes one below and exactly at the threshold, with positive and negative samples on either channel. This separates the magnitude compare from the sign handling and shows that the two channels are ORed. Step-size, update-period and clipping runs then show whether the step arithmetic saturates at mute. Zero-cross gating is exercised with a sign flip on one channel only, so the zero-cross path and the timeout path are seen to finish separately. Recovery runs feed steady quiet input, a single in-band frame, and an over-threshold frame during a pending step. Together these tell apart the wait timing, the band reset, the reference clamp and the pre-emption rule.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_W = 7;
  localparam logic [GAIN_W-1:0] GAIN_MAX = 7'h68;
  localparam logic [GAIN_W-1:0] GAIN_RST = 7'h30;

  // Level ladder in 16-bit full scale: idx 0 = -10 dB, then -8, -6, -4, -2 dB.
  function automatic logic [15:0] lvl_code(input logic [2:0] idx);
    case (idx)
      3'd0:    lvl_code = 16'd10362;
      3'd1:    lvl_code = 16'd13045;
      3'd2:    lvl_code = 16'd16423;
      3'd3:    lvl_code = 16'd20675;
      default: lvl_code = 16'd26029;
    endcase
  endfunction
endpackage

// File: rtl/agc_level_det.sv
module agc_level_det import agc_pkg::*; #(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_vld,
  input  logic [1:0][DW-1:0] smp,
  input  logic [1:0]         thr_sel,
  output logic               ovr,
  output logic               near,
  output logic [1:0]         zc
);
  localparam int SH = DW - 16;

  logic [1:0][DW-1:0] mag;
  logic [1:0]         sgn_q, sgn_n;
  logic [DW-1:0]      peak, thr_v, band_v;

  genvar c;
  for (c = 0; c < 2; c++) begin : g_ch
    assign mag[c]   = smp[c][DW-1] ? (~smp[c] + 1'b1) : smp[c];
    assign zc[c]    = smp[c][DW-1] ^ sgn_q[c];
    assign sgn_n[c] = frame_vld ? smp[c][DW-1] : sgn_q[c];
  end

  always_comb begin
    peak   = (mag[0] > mag[1]) ? mag[0] : mag[1];
    thr_v  = DW'(lvl_code({1'b0, thr_sel} + 3'd1)) << SH;
    band_v = DW'(lvl_code({1'b0, thr_sel})) << SH;
    ovr    = peak >= thr_v;
    near   = peak >= band_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sgn_q <= '0;
    else        sgn_q <= sgn_n;
  end
endmodule

// File: rtl/agc_seq.sv
module agc_seq import agc_pkg::*; #(
  parameter int CW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic              lim_en,
  input  logic              rcv_en,
  input  logic              ovr,
  input  logic              near,
  input  logic [2:0]        atten_sel,
  input  logic              lim_zc_en,
  input  logic [1:0]        lim_tm_sel,
  input  logic              rcv_zc_en,
  input  logic [1:0]        rcv_tm_sel,
  input  logic [1:0]        wait_sel,
  input  logic [1:0]        rise_sel,
  input  logic [GAIN_W-1:0] ref_code,
  input  logic [GAIN_W-1:0] gain_l,
  input  logic [GAIN_W-1:0] gain_r,
  input  logic              pend_any,
  output logic [GAIN_W-1:0] tgt,
  output logic              issue_imm,
  output logic              issue_zc,
  output logic              tmo_hit,
  output logic              lim_act
);
  logic              lim_act_q, lim_act_n, rcv_q, rcv_n;
  logic [2:0]        gap_q, gap_n;
  logic [CW-1:0]     tcnt_q, tcnt_n, tlim_q, tlim_n, wcnt_q, wcnt_n, wait_lim;
  logic [GAIN_W-1:0] tgt_q, base, lim_tgt, ref_c, rcv_tgt;
  logic [GAIN_W:0]   rsum;
  logic [3:0]        att;
  logic              lim_go, rcv_go, wait_full, rcv_arm;

  always_comb begin
    base      = (gain_l < gain_r) ? gain_l : gain_r;
    att       = {1'b0, atten_sel} + 4'd1;
    lim_tgt   = (base > GAIN_W'(att)) ? base - GAIN_W'(att) : '0;
    ref_c     = (ref_code > GAIN_MAX) ? GAIN_MAX : ref_code;
    rsum      = {1'b0, base} + (GAIN_W+1)'(rise_sel) + 1'b1;
    rcv_tgt   = (rsum > {1'b0, ref_c}) ? ref_c : rsum[GAIN_W-1:0];
    wait_lim  = CW'(512) << wait_sel;
    wait_full = (wcnt_q + 1'b1) >= wait_lim;
    rcv_arm   = frame_vld & lim_en & rcv_en & ~ovr & ~near & ~pend_any;
    lim_go    = frame_vld & lim_en & ovr & (~pend_any | rcv_q) & (gap_q == 3'd0);
    rcv_go    = rcv_arm & wait_full & (base < ref_c);
    issue_imm = (lim_go & ~lim_zc_en) | (rcv_go & ~rcv_zc_en);
    issue_zc  = (lim_go & lim_zc_en) | (rcv_go & rcv_zc_en);
    tgt       = lim_go ? lim_tgt : (rcv_go ? rcv_tgt : tgt_q);
    tmo_hit   = (tcnt_q + 1'b1) >= tlim_q;
    lim_act   = lim_act_q;
  end

  always_comb begin
    lim_act_n = frame_vld ? (lim_en & ovr) : lim_act_q;
    rcv_n     = (issue_imm | issue_zc) ? rcv_go : rcv_q;
    tcnt_n    = tcnt_q;
    tlim_n    = tlim_q;
    if (issue_zc) begin
      tcnt_n = '0;
      tlim_n = lim_go ? (CW'(129) << lim_tm_sel) : ((CW'(512) << rcv_tm_sel) + 1'b1);
    end else if (frame_vld && pend_any) begin
      tcnt_n = tcnt_q + 1'b1;
    end
    gap_n = gap_q;
    if (lim_go && !lim_zc_en)              gap_n = 3'((4'd1 << lim_tm_sel) - 4'd1);
    else if (frame_vld && gap_q != 3'd0)   gap_n = gap_q - 3'd1;
    wcnt_n = wcnt_q;
    if (frame_vld) begin
      if (!(lim_en && rcv_en) || ovr || near) wcnt_n = '0;
      else if (pend_any)                      wcnt_n = wcnt_q;
      else if (wait_full)                     wcnt_n = '0;
      else                                    wcnt_n = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_act_q <= 1'b0;
      rcv_q     <= 1'b0;
      gap_q     <= '0;
      tcnt_q    <= '0;
      tlim_q    <= '0;
      wcnt_q    <= '0;
      tgt_q     <= GAIN_RST;
    end else begin
      lim_act_q <= lim_act_n;
      rcv_q     <= rcv_n;
      gap_q     <= gap_n;
      tcnt_q    <= tcnt_n;
      tlim_q    <= tlim_n;
      wcnt_q    <= wcnt_n;
      tgt_q     <= tgt;
    end
  end

  // R9: an in-band frame always restarts the wait, so no recovery step follows it.
  assert_band_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && near && !ovr) |-> !issue_imm && !issue_zc);
endmodule

// File: rtl/agc_gain_chan.sv
module agc_gain_chan import agc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic              issue_imm,
  input  logic              issue_zc,
  input  logic              zc,
  input  logic              tmo_hit,
  input  logic [GAIN_W-1:0] tgt,
  input  logic              host_we,
  input  logic [GAIN_W-1:0] host_val,
  output logic [GAIN_W-1:0] gain,
  output logic              pend
);
  logic [GAIN_W-1:0] gain_n;
  logic              pend_n;

  always_comb begin
    gain_n = gain;
    pend_n = pend;
    if (issue_imm) begin
      gain_n = tgt;
      pend_n = 1'b0;
    end else if (issue_zc) begin
      pend_n = 1'b1;
    end else if (frame_vld && pend && (zc || tmo_hit)) begin
      gain_n = tgt;
      pend_n = 1'b0;
    end else if (host_we) begin
      gain_n = host_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain <= GAIN_RST;
      pend <= 1'b0;
    end else begin
      gain <= gain_n;
      pend <= pend_n;
    end
  end

  // R6: a pending code only lands on a frame.
  assert_hold_between_frames_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !frame_vld) |=> $stable(gain));
endmodule

// File: rtl/agc_limiter.sv
module agc_limiter import agc_pkg::*; #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  logic [DW-1:0]     smp_l,
  input  logic [DW-1:0]     smp_r,
  input  logic              lim_en,
  input  logic              rcv_en,
  input  logic [1:0]        thr_sel,
  input  logic [2:0]        atten_sel,
  input  logic              lim_zc_en,
  input  logic [1:0]        lim_tm_sel,
  input  logic              rcv_zc_en,
  input  logic [1:0]        rcv_tm_sel,
  input  logic [1:0]        wait_sel,
  input  logic [1:0]        rise_sel,
  input  logic [GAIN_W-1:0] ref_code,
  input  logic              host_wr_l,
  input  logic              host_wr_r,
  input  logic [GAIN_W-1:0] host_gain,
  output logic [GAIN_W-1:0] gain_l,
  output logic [GAIN_W-1:0] gain_r,
  output logic              done
);
  localparam int CW = 13;

  logic [1:0][DW-1:0]     smp;
  logic [1:0][GAIN_W-1:0] gain;
  logic [1:0]             pend, zc, host_we, host_wr;
  logic [GAIN_W-1:0]      tgt, host_val;
  logic                   ovr, near, issue_imm, issue_zc, tmo_hit, lim_act, pend_any;

  assign smp      = {smp_r, smp_l};
  assign host_wr  = {host_wr_r, host_wr_l};
  assign pend_any = |pend;
  assign host_val = (host_gain > GAIN_MAX) ? GAIN_MAX : host_gain;
  assign gain_l   = gain[0];
  assign gain_r   = gain[1];
  assign done     = ~lim_act & ~pend_any;

  agc_level_det #(.DW(DW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .smp(smp),
    .thr_sel(thr_sel), .ovr(ovr), .near(near), .zc(zc)
  );

  agc_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .lim_en(lim_en), .rcv_en(rcv_en),
    .ovr(ovr), .near(near), .atten_sel(atten_sel), .lim_zc_en(lim_zc_en),
    .lim_tm_sel(lim_tm_sel), .rcv_zc_en(rcv_zc_en), .rcv_tm_sel(rcv_tm_sel),
    .wait_sel(wait_sel), .rise_sel(rise_sel), .ref_code(ref_code),
    .gain_l(gain[0]), .gain_r(gain[1]), .pend_any(pend_any), .tgt(tgt),
    .issue_imm(issue_imm), .issue_zc(issue_zc), .tmo_hit(tmo_hit), .lim_act(lim_act)
  );

  genvar c;
  for (c = 0; c < 2; c++) begin : g_chan
    assign host_we[c] = host_wr[c] & ~lim_en & ~pend_any;
    agc_gain_chan u_chan (
      .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .issue_imm(issue_imm),
      .issue_zc(issue_zc), .zc(zc[c]), .tmo_hit(tmo_hit), .tgt(tgt),
      .host_we(host_we[c]), .host_val(host_val), .gain(gain[c]), .pend(pend[c])
    );
  end

  // R2: with the limiter enabled, only frames move the gains.
  assert_host_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_en && !frame_vld) |=> ($stable(gain_l) && $stable(gain_r)));

  // R4: an immediate limiter step leaves both channels equal.
  assert_common_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_imm && ovr) |=> (gain_l == gain_r));

  // R7: with done set and no stimulus, nothing moves.
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !frame_vld && !host_wr_l && !host_wr_r) |=> ($stable(gain_l) && $stable(gain_r)));

  // R8: a rise in automatic operation never exceeds the largest step.
  assert_rise_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gain_l > $past(gain_l)) && $past(lim_en)) |-> ((gain_l - $past(gain_l)) <= 7'd4));
endmodule

// File: tb/agc_limiter_bench.sv
module agc_limiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_vld = 1'b0;
  logic signed [15:0] smp_l = '0, smp_r = '0;
  logic lim_en = 0, rcv_en = 0, lim_zc_en = 0, rcv_zc_en = 0;
  logic [1:0] thr_sel = 0, lim_tm_sel = 0, rcv_tm_sel = 0, wait_sel = 0, rise_sel = 0;
  logic [2:0] atten_sel = 0;
  logic [6:0] ref_code = 7'h30, host_gain = 0;
  logic host_wr_l = 0, host_wr_r = 0;
  logic [6:0] gain_l, gain_r;
  logic done;

  always #10 clk = ~clk;

  agc_limiter u_agc_limiter (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .smp_l(smp_l), .smp_r(smp_r),
    .lim_en(lim_en), .rcv_en(rcv_en), .thr_sel(thr_sel), .atten_sel(atten_sel),
    .lim_zc_en(lim_zc_en), .lim_tm_sel(lim_tm_sel), .rcv_zc_en(rcv_zc_en),
    .rcv_tm_sel(rcv_tm_sel), .wait_sel(wait_sel), .rise_sel(rise_sel),
    .ref_code(ref_code), .host_wr_l(host_wr_l), .host_wr_r(host_wr_r),
    .host_gain(host_gain), .gain_l(gain_l), .gain_r(gain_r), .done(done)
  );

  int nvec = 0, nerr = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Reference model state
  int m_gl, m_gr, m_pl, m_pr, m_tgt, m_lact, m_rcv, m_gap, m_tcnt, m_tlim, m_wcnt, m_sl, m_sr;
  int lv[5] = '{10362, 13045, 16423, 20675, 26029};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gl = 'h30; m_gr = 'h30; m_pl = 0; m_pr = 0; m_tgt = 'h30; m_lact = 0;
      m_rcv = 0; m_gap = 0; m_tcnt = 0; m_tlim = 0; m_wcnt = 0; m_sl = 0; m_sr = 0;
    end else begin
      int pa, al, ar, pk, ov, nr, zl, zr, base, refc, limgo, rgo, wl, hit, t, wfull;
      pa = (m_pl || m_pr);
      if (frame_vld) begin
        al = (smp_l < 0) ? -int'(smp_l) : int'(smp_l);
        ar = (smp_r < 0) ? -int'(smp_r) : int'(smp_r);
        pk = (al > ar) ? al : ar;
        ov = (pk >= lv[thr_sel + 1]);
        nr = (pk >= lv[thr_sel]);
        zl = ((smp_l < 0) ? 1 : 0) != m_sl;
        zr = ((smp_r < 0) ? 1 : 0) != m_sr;
        base = (m_gl < m_gr) ? m_gl : m_gr;
        refc = (ref_code > 'h68) ? 'h68 : int'(ref_code);
        wl = 512 << wait_sel;
        wfull = (m_wcnt + 1 >= wl);
        hit = (m_tcnt + 1 >= m_tlim);
        limgo = lim_en && ov && (!pa || m_rcv) && (m_gap == 0);
        rgo = lim_en && rcv_en && !ov && !nr && !pa && wfull && (base < refc);
        if (!(limgo && !lim_zc_en) && m_gap > 0) m_gap--;
        if (limgo) begin
          t = base - (atten_sel + 1); if (t < 0) t = 0;
          m_tgt = t; m_rcv = 0;
          if (lim_zc_en) begin m_pl = 1; m_pr = 1; m_tcnt = 0; m_tlim = 129 << lim_tm_sel; end
          else begin m_gl = t; m_gr = t; m_pl = 0; m_pr = 0; m_gap = (1 << lim_tm_sel) - 1; end
        end else if (rgo) begin
          t = base + rise_sel + 1; if (t > refc) t = refc;
          m_tgt = t; m_rcv = 1;
          if (rcv_zc_en) begin m_pl = 1; m_pr = 1; m_tcnt = 0; m_tlim = (512 << rcv_tm_sel) + 1; end
          else begin m_gl = t; m_gr = t; end
        end else begin
          if (pa) m_tcnt++;
          if (m_pl && (zl || hit)) begin m_gl = m_tgt; m_pl = 0; end
          if (m_pr && (zr || hit)) begin m_gr = m_tgt; m_pr = 0; end
        end
        if (limgo && pa) m_tcnt++;
        if (!(lim_en && rcv_en) || ov || nr) m_wcnt = 0;
        else if (pa) m_wcnt = m_wcnt;
        else if (wfull) m_wcnt = 0;
        else m_wcnt++;
        m_lact = lim_en && ov;
        m_sl = (smp_l < 0); m_sr = (smp_r < 0);
      end
      if (!lim_en && !pa) begin
        if (host_wr_l) m_gl = (host_gain > 'h68) ? 'h68 : int'(host_gain);
        if (host_wr_r) m_gr = (host_gain > 'h68) ? 'h68 : int'(host_gain);
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      int md;
      md = (!m_lact && !m_pl && !m_pr);
      nvec++;
      if (int'(gain_l) != m_gl || int'(gain_r) != m_gr || int'(done) != md) begin
        nerr++;
        $display("FAIL %s model compare: got gl=%0h gr=%0h done=%0b expected gl=%0h gr=%0h done=%0b",
                 cur_req, gain_l, gain_r, done, m_gl, m_gr, md);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic frames(input int n, input int l, input int r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_vld = 1; smp_l = 16'(l); smp_r = 16'(r);
      @(negedge clk); frame_vld = 0;
    end
  endtask

  task automatic host(input logic wl, input logic wr, input int v);
    @(negedge clk); host_wr_l = wl; host_wr_r = wr; host_gain = 7'(v);
    @(negedge clk); host_wr_l = 0; host_wr_r = 0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gain_l", gain_l, 'h30); chk("R1 gain_r", gain_r, 'h30); chk("R1 done", done, 1);

    // R2 manual writes and clipping
    cur_req = "R2";
    host(1, 0, 'h20); chk("R2 write L", gain_l, 'h20);
    host(0, 1, 'h7F); chk("R2 clip R", gain_r, 'h68);
    host(1, 1, 'h40);

    // R3/R4 threshold boundary and step, immediate mode
    cur_req = "R3"; thr_sel = 0; atten_sel = 1; lim_tm_sel = 0; lim_en = 1;
    frames(1, 13044, 0);  chk("R3 below threshold", gain_l, 'h40);
    frames(1, 0, -13045); chk("R3 R4 step L", gain_l, 'h3E); chk("R4 step R", gain_r, 'h3E);
    chk("R7 done low while over", done, 0);
    host(1, 1, 'h10); chk("R2 write ignored", gain_l, 'h3E);
    cur_req = "R7"; frames(1, 100, 100); chk("R7 done after quiet", done, 1);

    // R5 update period of 4 frames
    cur_req = "R5"; lim_tm_sel = 2;
    frames(8, 20000, 0); chk("R5 two steps in 8 frames", gain_l, 'h3A);
    frames(1, 100, 100);

    // R4 clip at mute
    cur_req = "R4"; atten_sel = 7; lim_tm_sel = 0;
    frames(8, 0, 30000); chk("R4 clip L", gain_l, 0); chk("R4 clip R", gain_r, 0);
    frames(1, 30000, 0); chk("R4 stays mute", gain_r, 0);
    frames(1, 100, 100);

    // R6 zero-cross gating with timeout
    cur_req = "R6"; lim_en = 0; host(1, 1, 'h40); lim_en = 1;
    lim_zc_en = 1; atten_sel = 3;
    frames(1, 20000, 5000);
    frames(1, -100, 100);
    chk("R6 L at zero cross", gain_l, 'h3C); chk("R6 R waits", gain_r, 'h40); chk("R7 pending", done, 0);
    frames(127, -100, 100); chk("R6 R before timeout", gain_r, 'h40);
    frames(1, -100, 100);   chk("R6 R at timeout", gain_r, 'h3C); chk("R7 done after apply", done, 1);

    // R8 recovery with clamp
    cur_req = "R8"; lim_en = 0; frames(1, 100, 100); host(1, 1, 'h2B);
    lim_zc_en = 0; rcv_en = 1; rcv_zc_en = 0; wait_sel = 0; rise_sel = 1; ref_code = 'h30; lim_en = 1;
    frames(511, 100, 100); chk("R8 before wait", gain_l, 'h2B);
    frames(1, 100, 100);   chk("R8 first rise", gain_l, 'h2D);
    frames(512, 100, 100); chk("R8 second rise", gain_r, 'h2F);
    frames(512, 100, 100); chk("R8 clamp to ref", gain_l, 'h30);
    frames(512, 100, 100); chk("R8 no rise at ref", gain_l, 'h30);

    // R9 band reset, with B-1 counting as quiet
    cur_req = "R9"; lim_en = 0; host(1, 1, 'h20); lim_en = 1;
    frames(400, 10361, -10361);
    frames(1, 10362, 0);
    frames(511, 10361, 0); chk("R9 wait restarted", gain_l, 'h20);
    frames(1, 10361, 0);   chk("R9 rise after full wait", gain_l, 'h22);

    // R10 recovery zero-cross timeout
    cur_req = "R10"; rcv_zc_en = 1; rcv_tm_sel = 0; rise_sel = 0;
    frames(512, 100, 100); chk("R10 pending", done, 0);
    frames(512, 100, 100); chk("R10 before timeout", gain_l, 'h22);
    frames(1, 100, 100);   chk("R10 at timeout", gain_r, 'h23); chk("R10 done", done, 1);

    // R11 pre-emption of recovery by the limiter
    cur_req = "R11"; atten_sel = 0; lim_zc_en = 0; lim_tm_sel = 0;
    frames(512, 100, 100);
    frames(1, -100, 100); chk("R11 L rose", gain_l, 'h24); chk("R11 R pending", gain_r, 'h23);
    frames(1, 20000, 100); chk("R11 limit from min L", gain_l, 'h22); chk("R11 limit R", gain_r, 'h22);
    chk("R11 done low", done, 0);

    // R12 disable with a step in flight
    cur_req = "R12"; lim_zc_en = 1; rcv_en = 0;
    frames(1, 20000, 100);
    lim_en = 0;
    frames(128, 20000, 100); chk("R12 still pending", gain_l, 'h22); chk("R12 done low", done, 0);
    frames(1, 20000, 100);   chk("R12 step completes", gain_r, 'h21); chk("R12 done", done, 1);
    frames(5, 20000, 100);   chk("R12 no new step", gain_l, 'h21); chk("R12 done stays", done, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule